// File: doc/BRIEF.md
# Serial Port Interrupt Request Controller

This block turns the status flags of an asynchronous serial port into interrupt and DMA request lines. The port datapath sends one-cycle set pulses when a transmit buffer empties, when a transmission finishes, when a receive buffer fills, or when it detects an overrun, a parity error or a framing error. The controller keeps these events in flags. The CPU clears a flag with a clear strobe. A DMA or data-transfer controller clears a data flag with its acknowledge pulse.

There are four request sources: transmit, transmit-end, receive and error. Each source has its own enable bit and its own output line. A registered, prioritised code reports which enabled source is pending, so an interrupt controller can pick a vector. The transmit and receive requests are also driven out as DMA triggers.

The reset input is asynchronous and active low. Inside the block it is released synchronously, after a two-stage synchronizer.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset the transmit-empty and transmit-end flags are 1 and all other flags are 0. All request lines, both DMA triggers and the pending code read 0 until an enable bit is set.
- R2: The transmit request (`irq_tx_o`) is 1 one clock after the transmit-empty flag (flag bit 0) and the transmit enable (`src_en_i[0]`) are both 1. It is 0 one clock after either of them is 0.
- R3: The transmit-end request (`irq_tend_o`) is 1 only when, one clock earlier, the transmit-end flag (flag bit 1) and the transmit-end enable (`src_en_i[1]`) were both 1.
- R4: The receive request (`irq_rx_o`) follows the receive-full flag (flag bit 2) gated by `src_en_i[2]`, one clock later.
- R5: The error request (`irq_err_o`) is 1 one clock after any of the overrun (bit 3), parity (bit 4) or framing (bit 5) flags is 1 while `src_en_i[3]` is 1. It stays 0 while `src_en_i[3]` is 0.
- R6: A `dma_ack_tx_i` pulse clears the transmit-empty flag and a `dma_ack_rx_i` pulse clears the receive-full flag, with no CPU clear. Neither acknowledge changes any error flag.
- R7: If a set pulse for a flag arrives in the same cycle as its clear strobe or its DMA acknowledge, the flag ends up 1.
- R8: `pend_code_o` names the highest-priority active request, with the same latency as the request lines. Error gives 4, receive gives 3, transmit gives 2, transmit-end gives 1, and no request gives 0. When transmit and transmit-end are both active, transmit is reported.
- R9: If the transmit-empty and transmit-end flags are cleared in the same cycle, the transmit-end request stays 0 afterwards. The event is not held anywhere else.
- R10: `dma_req_o[0]` equals the transmit request and `dma_req_o[1]` equals the receive request.
- R11: A clear strobe on `flag_clr_i[k]` with no set pulse on that flag clears flag k at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_set_i | input | 6 | One-cycle set pulses: bit 0 tx-empty, 1 tx-end, 2 rx-full, 3 overrun, 4 parity, 5 framing |
| flag_clr_i | input | 6 | CPU clear strobes, same bit order as flag_set_i |
| src_en_i | input | 4 | Source enables: bit 0 tx, 1 tx-end, 2 rx, 3 error |
| dma_ack_tx_i | input | 1 | DMA acknowledge for a transmit transfer |
| dma_ack_rx_i | input | 1 | DMA acknowledge for a receive transfer |
| irq_tx_o | output | 1 | Transmit request |
| irq_tend_o | output | 1 | Transmit-end request |
| irq_rx_o | output | 1 | Receive request |
| irq_err_o | output | 1 | Error request |
| pend_code_o | output | 3 | Prioritised pending-source code |
| dma_req_o | output | 2 | DMA triggers: bit 0 transmit, bit 1 receive |

## Verification
The bench clears both transmit flags in a single cycle and checks that the transmit-end request stays low for several cycles. A design that latched the transmit-end event would raise it again later. It drives a set pulse together with a clear strobe, and again together with a DMA acknowledge, which catches a design where the clear wins. It sends DMA acknowledges while an error flag is held and checks that the error request stays up, so an acknowledge that reached the error flags would drop it. It also walks the pending code down from error to nothing, which exposes a swapped priority, for example transmit-end reported ahead of transmit.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  // flag positions
  localparam int NUM_FLAGS = 6;
  localparam int FL_TXE    = 0;
  localparam int FL_TEND   = 1;
  localparam int FL_RXF    = 2;
  localparam int FL_ERR_LO = 3;

  // request sources
  localparam int NUM_SRC  = 4;
  localparam int SRC_TX   = 0;
  localparam int SRC_TEND = 1;
  localparam int SRC_RX   = 2;
  localparam int SRC_ERR  = 3;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PEND_NONE = 3'd0,
    PEND_TEND = 3'd1,
    PEND_TX   = 3'd2,
    PEND_RX   = 3'd3,
    PEND_ERR  = 3'd4
  } pend_code_e;

endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/sio_flag_bank.sv
module sio_flag_bank #(
  parameter int             NF      = 6,
  parameter logic [NF-1:0]  RST_VAL = 6'b000011,
  parameter int             TX_IDX  = 0,
  parameter int             RX_IDX  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic          ack_tx_i,
  input  logic          ack_rx_i,
  output logic [NF-1:0] flags_o
);

  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic ack;
    logic upd;
    logic flag_d;
    logic flag_q;

    if (g == TX_IDX) begin : g_ack_tx
      assign ack = ack_tx_i;
    end else if (g == RX_IDX) begin : g_ack_rx
      assign ack = ack_rx_i;
    end else begin : g_no_ack
      assign ack = 1'b0;
    end

    // a set pulse overrides any clear in the same cycle
    always_comb begin
      upd    = set_i[g] | clr_i[g] | ack;
      flag_d = set_i[g] | (flag_q & ~(clr_i[g] | ack));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= RST_VAL[g];
      else if (upd) flag_q <= flag_d;
    end

    assign flags_o[g] = flag_q;

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_o[g]);

    p_cpu_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);

    if (g != TX_IDX && g != RX_IDX) begin : g_ack_immune
      p_err_ack_immune_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[g] && !clr_i[g]) |=> flags_o[g]);
    end
  end

  p_dma_tx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tx_i && !set_i[TX_IDX]) |=> !flags_o[TX_IDX]);

  p_dma_rx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rx_i && !set_i[RX_IDX]) |=> !flags_o[RX_IDX]);

endmodule

// File: rtl/sio_prio_enc.sv
module sio_prio_enc
  import sio_irq_pkg::*;
#(
  parameter int NS = NUM_SRC
) (
  input  logic [NS-1:0] req_i,
  output pend_code_e    code_o
);

  // order: error, receive, transmit, transmit-end
  always_comb begin
    if (req_i[SRC_ERR])       code_o = PEND_ERR;
    else if (req_i[SRC_RX])   code_o = PEND_RX;
    else if (req_i[SRC_TX])   code_o = PEND_TX;
    else if (req_i[SRC_TEND]) code_o = PEND_TEND;
    else                      code_o = PEND_NONE;
  end

endmodule

// File: rtl/sio_req_reg.sv
module sio_req_reg
  import sio_irq_pkg::*;
#(
  parameter int NF     = NUM_FLAGS,
  parameter int NS     = NUM_SRC,
  parameter int ERR_LO = FL_ERR_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NF-1:0]     flags_i,
  input  logic [NS-1:0]     en_i,
  output logic [NS-1:0]     req_o,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        dma_o
);

  logic [NS-1:0] raw;
  logic          err_any;
  pend_code_e    code_d;
  pend_code_e    code_q;
  logic [NS-1:0] req_q;
  logic [1:0]    dma_d;
  logic [1:0]    dma_q;
  logic          upd;

  always_comb begin
    err_any = 1'b0;
    for (int i = ERR_LO; i < NF; i++) err_any = err_any | flags_i[i];
  end

  always_comb begin
    raw           = '0;
    raw[SRC_TX]   = flags_i[FL_TXE]  & en_i[SRC_TX];
    raw[SRC_TEND] = flags_i[FL_TEND] & en_i[SRC_TEND];
    raw[SRC_RX]   = flags_i[FL_RXF]  & en_i[SRC_RX];
    raw[SRC_ERR]  = err_any          & en_i[SRC_ERR];
    dma_d         = {raw[SRC_RX], raw[SRC_TX]};
    upd           = (raw != req_q);
  end

  sio_prio_enc #(.NS(NS)) u_enc (
    .req_i  (raw),
    .code_o (code_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      code_q <= PEND_NONE;
      dma_q  <= '0;
    end else if (upd) begin
      req_q  <= raw;
      code_q <= code_d;
      dma_q  <= dma_d;
    end
  end

  assign req_o  = req_q;
  assign code_o = code_q;
  assign dma_o  = dma_q;

  p_tx_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i[FL_TXE] && en_i[SRC_TX]) |=> req_o[SRC_TX]);

  p_tend_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o[SRC_TEND]) |-> $past(flags_i[FL_TEND] && en_i[SRC_TEND]));

  p_rx_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i[FL_RXF] && en_i[SRC_RX]) |=> req_o[SRC_RX]);

  p_err_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o[SRC_ERR]) |-> $past(err_any && en_i[SRC_ERR]));

  p_code_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == PEND_NONE) |-> (req_o == '0));

  p_tx_before_tend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o[SRC_TX] && !req_o[SRC_RX] && !req_o[SRC_ERR]) |-> (code_o == PEND_TX));

  p_dma_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_o == {req_o[SRC_RX], req_o[SRC_TX]}));

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int NF          = NUM_FLAGS,
  parameter int NS          = NUM_SRC,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NF-1:0]     flag_set_i,
  input  logic [NF-1:0]     flag_clr_i,
  input  logic [NS-1:0]     src_en_i,
  input  logic              dma_ack_tx_i,
  input  logic              dma_ack_rx_i,
  output logic              irq_tx_o,
  output logic              irq_tend_o,
  output logic              irq_rx_o,
  output logic              irq_err_o,
  output logic [CODE_W-1:0] pend_code_o,
  output logic [1:0]        dma_req_o
);

  localparam logic [NF-1:0] FLAG_RST = NF'((1 << FL_TXE) | (1 << FL_TEND));

  logic          srst_n;
  logic [NF-1:0] flags;
  logic [NS-1:0] req;

  sio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sio_flag_bank #(
    .NF      (NF),
    .RST_VAL (FLAG_RST),
    .TX_IDX  (FL_TXE),
    .RX_IDX  (FL_RXF)
  ) u_flags (
    .clk      (clk),
    .rst_n    (srst_n),
    .set_i    (flag_set_i),
    .clr_i    (flag_clr_i),
    .ack_tx_i (dma_ack_tx_i),
    .ack_rx_i (dma_ack_rx_i),
    .flags_o  (flags)
  );

  sio_req_reg #(
    .NF     (NF),
    .NS     (NS),
    .ERR_LO (FL_ERR_LO)
  ) u_req (
    .clk     (clk),
    .rst_n   (srst_n),
    .flags_i (flags),
    .en_i    (src_en_i),
    .req_o   (req),
    .code_o  (pend_code_o),
    .dma_o   (dma_req_o)
  );

  assign irq_tx_o   = req[SRC_TX];
  assign irq_tend_o = req[SRC_TEND];
  assign irq_rx_o   = req[SRC_RX];
  assign irq_err_o  = req[SRC_ERR];

  // losing both transmit flags together must not leave a transmit-end request behind
  p_tend_lost_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (flag_clr_i[FL_TXE] && flag_clr_i[FL_TEND] && !flag_set_i[FL_TEND]) |=> ##1 !irq_tend_o);

endmodule

// File: tb/sio_irq_ctrl_bench.sv
module sio_irq_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] flag_set;
  logic [5:0] flag_clr;
  logic [3:0] src_en;
  logic       ack_tx;
  logic       ack_rx;
  logic       irq_tx, irq_tend, irq_rx, irq_err;
  logic [2:0] code;
  logic [1:0] dma_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sio_irq_ctrl u_sio_irq_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .flag_set_i   (flag_set),
    .flag_clr_i   (flag_clr),
    .src_en_i     (src_en),
    .dma_ack_tx_i (ack_tx),
    .dma_ack_rx_i (ack_rx),
    .irq_tx_o     (irq_tx),
    .irq_tend_o   (irq_tend),
    .irq_rx_o     (irq_rx),
    .irq_err_o    (irq_err),
    .pend_code_o  (code),
    .dma_req_o    (dma_req)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one-cycle stimulus, applied at a falling edge
  task automatic pulse(input logic [5:0] s, input logic [5:0] c, input logic at, input logic ar);
    flag_set = s; flag_clr = c; ack_tx = at; ack_rx = ar;
    @(negedge clk);
    flag_set = '0; flag_clr = '0; ack_tx = 1'b0; ack_rx = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 irq_tx",   {7'd0, irq_tx},   8'd0);
    check("R1 irq_tend", {7'd0, irq_tend}, 8'd0);
    check("R1 irq_rx",   {7'd0, irq_rx},   8'd0);
    check("R1 irq_err",  {7'd0, irq_err},  8'd0);
    check("R1 code",     {5'd0, code},     8'd0);
    check("R1 dma",      {6'd0, dma_req},  8'd0);
    src_en = 4'b1111; step();
    check("R1 txe reset one", {7'd0, irq_tx},   8'd1);
    check("R1 tend reset one",{7'd0, irq_tend}, 8'd1);
    check("R1 rx reset zero", {7'd0, irq_rx},   8'd0);
    check("R1 err reset zero",{7'd0, irq_err},  8'd0);
    check("R8 tx over tend",  {5'd0, code},     8'd2);
    src_en = 4'b0000; step();
  endtask

  task automatic t_tx_dma();
    pulse(6'b000001, 6'b0, 1'b0, 1'b0); step();
    src_en = 4'b0001; step();
    check("R2 tx req",  {7'd0, irq_tx},  8'd1);
    check("R10 dma tx", {6'd0, dma_req}, 8'd1);
    pulse(6'b0, 6'b0, 1'b1, 1'b0); step();
    check("R6 dma ack clears tx", {7'd0, irq_tx},  8'd0);
    check("R10 dma tx drop",      {6'd0, dma_req}, 8'd0);
    pulse(6'b000001, 6'b0, 1'b1, 1'b0); step();
    check("R7 set beats ack tx", {7'd0, irq_tx}, 8'd1);
    src_en = 4'b0000; step();
    check("R2 tx disabled", {7'd0, irq_tx}, 8'd0);
  endtask

  task automatic t_tend_lost();
    pulse(6'b000011, 6'b0, 1'b0, 1'b0); step();
    src_en = 4'b0010; step();
    check("R3 tend req", {7'd0, irq_tend}, 8'd1);
    check("R8 tend code",{5'd0, code},     8'd1);
    pulse(6'b0, 6'b000001, 1'b0, 1'b0); step();
    check("R9 tend kept after txe-only clear", {7'd0, irq_tend}, 8'd1);
    pulse(6'b000001, 6'b0, 1'b0, 1'b0); step();
    pulse(6'b0, 6'b000011, 1'b0, 1'b0); step();
    check("R9 tend lost", {7'd0, irq_tend}, 8'd0);
    repeat (3) step();
    check("R9 tend stays lost", {7'd0, irq_tend}, 8'd0);
    src_en = 4'b0000; step();
    pulse(6'b000010, 6'b0, 1'b0, 1'b0); step();
    check("R3 tend disabled", {7'd0, irq_tend}, 8'd0);
  endtask

  task automatic t_rx();
    src_en = 4'b0100; step();
    check("R4 rx idle", {7'd0, irq_rx}, 8'd0);
    pulse(6'b000100, 6'b0, 1'b0, 1'b0); step();
    check("R4 rx req",  {7'd0, irq_rx},  8'd1);
    check("R10 dma rx", {6'd0, dma_req}, 8'd2);
    check("R8 rx code", {5'd0, code},    8'd3);
    pulse(6'b0, 6'b0, 1'b0, 1'b1); step();
    check("R6 dma ack clears rx", {7'd0, irq_rx}, 8'd0);
    pulse(6'b000100, 6'b000100, 1'b0, 1'b1); step();
    check("R7 set beats clear and ack", {7'd0, irq_rx}, 8'd1);
    pulse(6'b0, 6'b000100, 1'b0, 1'b0); step();
    check("R11 cpu clear rx", {7'd0, irq_rx}, 8'd0);
    src_en = 4'b0000; step();
  endtask

  task automatic t_err();
    src_en = 4'b1000;
    pulse(6'b010000, 6'b0, 1'b0, 1'b0); step();
    check("R5 parity err", {7'd0, irq_err}, 8'd1);
    check("R8 err code",   {5'd0, code},    8'd4);
    pulse(6'b0, 6'b0, 1'b1, 1'b1); step();
    check("R6 acks leave errors", {7'd0, irq_err}, 8'd1);
    pulse(6'b010000, 6'b010000, 1'b0, 1'b0); step();
    check("R7 set beats clear err", {7'd0, irq_err}, 8'd1);
    pulse(6'b0, 6'b010000, 1'b0, 1'b0); step();
    check("R11 clear parity", {7'd0, irq_err}, 8'd0);
    pulse(6'b001000, 6'b0, 1'b0, 1'b0); step();
    check("R5 overrun err", {7'd0, irq_err}, 8'd1);
    pulse(6'b0, 6'b001000, 1'b0, 1'b0); step();
    pulse(6'b100000, 6'b0, 1'b0, 1'b0); step();
    check("R5 framing err", {7'd0, irq_err}, 8'd1);
    src_en = 4'b0000; step();
    check("R5 err disabled", {7'd0, irq_err}, 8'd0);
    pulse(6'b0, 6'b100000, 1'b0, 1'b0); step();
  endtask

  task automatic t_prio();
    pulse(6'b001111, 6'b0, 1'b0, 1'b0); step();
    src_en = 4'b1111; step();
    check("R8 err first", {5'd0, code}, 8'd4);
    pulse(6'b0, 6'b001000, 1'b0, 1'b0); step();
    check("R8 rx next", {5'd0, code}, 8'd3);
    pulse(6'b0, 6'b000100, 1'b0, 1'b0); step();
    check("R8 tx next", {5'd0, code}, 8'd2);
    pulse(6'b0, 6'b000001, 1'b0, 1'b0); step();
    check("R8 tend last", {5'd0, code}, 8'd1);
    pulse(6'b0, 6'b000010, 1'b0, 1'b0); step();
    check("R8 none", {5'd0, code}, 8'd0);
    src_en = 4'b0000; step();
  endtask

  initial begin
    rst_n = 1'b0; flag_set = '0; flag_clr = '0; src_en = '0;
    ack_tx = 1'b0; ack_rx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_dma();
    t_tend_lost();
    t_rx();
    t_err();
    t_prio();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule